// File: doc/BRIEF.md
# Multi-Cell Lithium-Ion Pack Protection Controller

This block is the digital state controller of a three- or four-cell lithium-ion pack protector. Analog comparators outside the block report four flags for each cell. The first says the cell is above the charge-cut level. The second says it is below the charge-release level. The third says it is below the discharge-cut level. The fourth says it is above the discharge-release level. The controller reads one cell per sample tick, in ascending cell order. A scan is complete once every active cell has been read. From the scan results it drives enables for the charge switch and the discharge switch, and a sleep indication.

A fault trips only after it has been seen on consecutive scans. Each trip has hysteresis: the release is judged by the second pair of flags, not by the trip flags. While the block is in the overcharge band, a small sensed discharge current turns the charge switch back on, so that discharge current does not flow through the switch body diode. An undervoltage puts the block to sleep. Only a wakeup from an attached charger ends sleep. Recovery charging from sleep uses a pulsed charge switch. The discharge switch stays off until a full scan shows every cell above the discharge-release level.

Top module: `batt_guard`

## Requirements
- R1: `cell3_mode_i`=1 selects three cells (bits 0..2 of each flag vector). `cell3_mode_i`=0, the default low level, selects four cells (bits 0..3). In three-cell mode the flags at bit 3 have no effect on any output.
- R2: After reset, both switch enables and `sleep_o` are 0 until the first complete scan. After that scan, with no fault, `dsg_on_o`=1, `chg_on_o`=`chg_en_i` and `sleep_o`=0.
- R3: If any active cell shows `ov_trip_i` on QUAL_SCANS consecutive scans, `chg_on_o` goes to 0 and `dsg_on_o` stays 1.
- R4: A failing scan followed by a passing scan clears the qualification count. A single failing scan (with QUAL_SCANS=2) trips nothing.
- R5: After an overcharge trip, `chg_on_o` stays 0 until a complete scan shows `ov_rel_i` set for every active cell. Clearing `ov_trip_i` alone does not release it.
- R6: While in the overcharge state, `chg_on_o` equals `dsg_sense_i` AND `chg_en_i`.
- R7: `chg_on_o` is 0 in every state whenever `chg_en_i` is 0.
- R8: If any active cell shows `uv_trip_i` on QUAL_SCANS consecutive scans, both enables go to 0 and `sleep_o` goes to 1. This holds even when an overcharge trip qualifies on the same scan.
- R9: The sleep state is left only when `wake_i` is 1. Cell flags alone, including all cells above release, do not end it.
- R10: During recovery after a wakeup, `sleep_o`=1 and `dsg_on_o`=0. `chg_on_o` (with `chg_en_i`=1) is high for PULSE_ON_CYC cycles and then low for PULSE_OFF_CYC cycles, repeating.
- R11: Recovery ends when a complete scan shows `uv_rel_i` set for every active cell. The block then returns to normal with `dsg_on_o`=1 and `sleep_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell3_mode_i | input | 1 | 1 = three cells, 0 = four cells |
| chg_en_i | input | 1 | Charge permitted when high |
| wake_i | input | 1 | Charger-attached wakeup |
| dsg_sense_i | input | 1 | Discharge current above the small threshold |
| ov_trip_i | input | MAX_CELLS | Per cell: above charge-cut level |
| ov_rel_i | input | MAX_CELLS | Per cell: below charge-release level |
| uv_trip_i | input | MAX_CELLS | Per cell: below discharge-cut level |
| uv_rel_i | input | MAX_CELLS | Per cell: above discharge-release level |
| chg_on_o | output | 1 | Charge switch enable |
| dsg_on_o | output | 1 | Discharge switch enable |
| sleep_o | output | 1 | Sleep / recovery indication |

## Verification
The outputs are decoded from the registered state and pulse phase, and are gated by the live `chg_en_i` and `dsg_sense_i`. Those two gating inputs therefore take effect within the same cycle. The bench drives them just after a rising edge and has them checked at the following falling edge. A state change is due at the end of the scan that completes qualification. That takes at most QUAL_SCANS+1 scans of TICK_DIV×cells cycles. The driver waits a settle window longer than that before queueing each expectation, and the monitor compares it at the next falling edge. Pulse run lengths in recovery are counted cycle by cycle at falling edges, starting from a rising edge of `chg_on_o`.

// File: rtl/bg_pkg.sv
package bg_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_NORMAL  = 3'd1,
        ST_OVCH    = 3'd2,
        ST_SLEEP   = 3'd3,
        ST_RECOVER = 3'd4
    } bg_state_e;

    // Aggregate result of one scan over the active cells
    typedef struct packed {
        logic any_ov;      // some cell above charge-cut
        logic all_ov_rel;  // every cell below charge-release
        logic any_uv;      // some cell below discharge-cut
        logic all_uv_rel;  // every cell above discharge-release
    } scan_flags_t;

    localparam scan_flags_t SCAN_INIT = '{any_ov: 1'b0, all_ov_rel: 1'b1,
                                          any_uv: 1'b0, all_uv_rel: 1'b1};

endpackage

// File: rtl/bg_tick_gen.sv
module bg_tick_gen #(
    parameter int DIV = 425000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CW'(DIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bg_cell_scan.sv
module bg_cell_scan
    import bg_pkg::*;
#(
    parameter int MAX_CELLS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 three_cell_i,
    input  logic [MAX_CELLS-1:0] ov_trip_i,
    input  logic [MAX_CELLS-1:0] ov_rel_i,
    input  logic [MAX_CELLS-1:0] uv_trip_i,
    input  logic [MAX_CELLS-1:0] uv_rel_i,
    output logic                 scan_done_o,
    output scan_flags_t          scan_res_o
);
    localparam int IW = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
    localparam logic [IW-1:0] LAST_FULL  = IW'(MAX_CELLS - 1);
    localparam logic [IW-1:0] LAST_SHORT = IW'(MAX_CELLS - 2);

    typedef struct packed {
        logic [IW-1:0] idx;
        scan_flags_t   acc;
    } scan_reg_t;

    scan_reg_t   r_d, r_q;
    logic [IW-1:0] last_idx;
    scan_flags_t cur;

    always_comb begin
        last_idx = three_cell_i ? LAST_SHORT : LAST_FULL;
        cur.any_ov     = r_q.acc.any_ov     | ov_trip_i[r_q.idx];
        cur.all_ov_rel = r_q.acc.all_ov_rel & ov_rel_i[r_q.idx];
        cur.any_uv     = r_q.acc.any_uv     | uv_trip_i[r_q.idx];
        cur.all_uv_rel = r_q.acc.all_uv_rel & uv_rel_i[r_q.idx];

        r_d         = r_q;
        scan_done_o = 1'b0;
        scan_res_o  = cur;
        if (tick_i) begin
            if (r_q.idx >= last_idx) begin
                scan_done_o = 1'b1;
                r_d.idx     = '0;
                r_d.acc     = SCAN_INIT;
            end else begin
                r_d.idx = r_q.idx + 1'b1;
                r_d.acc = cur;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{idx: '0, acc: SCAN_INIT};
        else        r_q <= r_d;
    end

    // R1: in three-cell mode the scan closes on the third cell
    assert_three_cell_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && three_cell_i && r_q.idx == LAST_SHORT) |-> scan_done_o);
endmodule

// File: rtl/bg_qual.sv
module bg_qual #(
    parameter int QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic fail_i,
    input  logic clr_i,
    output logic trip_o
);
    localparam int CW = $clog2(QUAL + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        trip_o = sample_i && fail_i && !clr_i && ((32'(cnt_q) + 1) >= QUAL);
        cnt_d  = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (sample_i)
            cnt_d = !fail_i ? '0 : (cnt_q == CW'(QUAL)) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a passing scan wipes the persistence count
    assert_clear_on_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !fail_i && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bg_pulse.sv
module bg_pulse #(
    parameter int ON_CYC  = 1400000,
    parameter int OFF_CYC = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic phase_o
);
    localparam int PERIOD = ON_CYC + OFF_CYC;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        phase_o = active_i && (cnt_q < CW'(ON_CYC));
        if (!active_i)                    cnt_d = '0;
        else if (cnt_q == CW'(PERIOD - 1)) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: every recovery episode opens with the on phase
    assert_phase_starts_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_i) |-> phase_o);
endmodule

// File: rtl/batt_guard.sv
module batt_guard
    import bg_pkg::*;
#(
    parameter int MAX_CELLS     = 4,
    parameter int TICK_DIV      = 425000,
    parameter int QUAL_SCANS    = 2,
    parameter int PULSE_ON_CYC  = 1400000,
    parameter int PULSE_OFF_CYC = 2000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cell3_mode_i,
    input  logic                 chg_en_i,
    input  logic                 wake_i,
    input  logic                 dsg_sense_i,
    input  logic [MAX_CELLS-1:0] ov_trip_i,
    input  logic [MAX_CELLS-1:0] ov_rel_i,
    input  logic [MAX_CELLS-1:0] uv_trip_i,
    input  logic [MAX_CELLS-1:0] uv_rel_i,
    output logic                 chg_on_o,
    output logic                 dsg_on_o,
    output logic                 sleep_o
);
    localparam int NCOND  = 2;
    localparam int C_OV   = 0;
    localparam int C_UV   = 1;

    typedef struct packed {
        bg_state_e st;
    } top_reg_t;

    top_reg_t    r_d, r_q;
    logic        tick, scan_done, phase;
    scan_flags_t scan_res;
    logic [NCOND-1:0] cond_fail, cond_clr, cond_trip;

    bg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    bg_cell_scan #(.MAX_CELLS(MAX_CELLS)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .three_cell_i(cell3_mode_i),
        .ov_trip_i(ov_trip_i), .ov_rel_i(ov_rel_i),
        .uv_trip_i(uv_trip_i), .uv_rel_i(uv_rel_i),
        .scan_done_o(scan_done), .scan_res_o(scan_res)
    );

    always_comb begin
        cond_fail[C_OV] = scan_res.any_ov;
        cond_fail[C_UV] = scan_res.any_uv;
        cond_clr[C_OV]  = !(r_q.st == ST_INIT || r_q.st == ST_NORMAL);
        cond_clr[C_UV]  = !(r_q.st == ST_INIT || r_q.st == ST_NORMAL ||
                            r_q.st == ST_OVCH);
    end

    for (genvar g = 0; g < NCOND; g++) begin : g_qual
        bg_qual #(.QUAL(QUAL_SCANS)) u_qual (
            .clk(clk), .rst_n(rst_n), .sample_i(scan_done),
            .fail_i(cond_fail[g]), .clr_i(cond_clr[g]), .trip_o(cond_trip[g])
        );
    end

    bg_pulse #(.ON_CYC(PULSE_ON_CYC), .OFF_CYC(PULSE_OFF_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .active_i(r_q.st == ST_RECOVER), .phase_o(phase)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_INIT: begin
                if (scan_done)
                    r_d.st = cond_trip[C_UV] ? ST_SLEEP :
                             cond_trip[C_OV] ? ST_OVCH  : ST_NORMAL;
            end
            ST_NORMAL: begin
                if (cond_trip[C_UV])      r_d.st = ST_SLEEP;
                else if (cond_trip[C_OV]) r_d.st = ST_OVCH;
            end
            ST_OVCH: begin
                if (cond_trip[C_UV])                         r_d.st = ST_SLEEP;
                else if (scan_done && scan_res.all_ov_rel)   r_d.st = ST_NORMAL;
            end
            ST_SLEEP: begin
                if (wake_i) r_d.st = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (scan_done && scan_res.all_uv_rel) r_d.st = ST_NORMAL;
            end
            default: r_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_INIT};
        else        r_q <= r_d;
    end

    always_comb begin
        chg_on_o = chg_en_i && ((r_q.st == ST_NORMAL) ||
                                (r_q.st == ST_OVCH && dsg_sense_i) ||
                                (r_q.st == ST_RECOVER && phase));
        dsg_on_o = (r_q.st == ST_NORMAL) || (r_q.st == ST_OVCH);
        sleep_o  = (r_q.st == ST_SLEEP) || (r_q.st == ST_RECOVER);
    end

    // R2: the power-up state is held until a scan completes
    assert_init_until_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_INIT && !scan_done) |=> (r_q.st == ST_INIT));

    // R3: overcharge is entered only at a scan boundary
    assert_ov_at_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_OVCH) |-> $past(scan_done));

    // R9: sleep persists without a wakeup
    assert_sleep_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SLEEP && !wake_i) |=> (r_q.st == ST_SLEEP));

    // R11: recovery ends only on a scan with every cell above release
    assert_recover_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.st == ST_RECOVER) |-> $past(scan_done && scan_res.all_uv_rel));
endmodule

// File: tb/batt_guard_bench.sv
`timescale 1ns/1ps
module batt_guard_bench;
    localparam int NC    = 4;
    localparam int DIV   = 3;
    localparam int P_ON  = 7;
    localparam int P_OFF = 10;
    localparam int SETTLE = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell3 = 1'b0, chg_en = 1'b1, wake = 1'b0, dsense = 1'b0;
    logic [NC-1:0] ovt = '0, ovr = '1, uvt = '0, uvr = '1;
    logic chg_on, dsg_on, slp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  c;
        logic  d;
        logic  s;
        string tag;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    batt_guard #(.MAX_CELLS(NC), .TICK_DIV(DIV), .QUAL_SCANS(2),
                 .PULSE_ON_CYC(P_ON), .PULSE_OFF_CYC(P_OFF)) u_batt_guard (
        .clk(clk), .rst_n(rst_n), .cell3_mode_i(cell3), .chg_en_i(chg_en),
        .wake_i(wake), .dsg_sense_i(dsense), .ov_trip_i(ovt), .ov_rel_i(ovr),
        .uv_trip_i(uvt), .uv_rel_i(uvr),
        .chg_on_o(chg_on), .dsg_on_o(dsg_on), .sleep_o(slp)
    );

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if ({chg_on, dsg_on, slp} !== {e.c, e.d, e.s}) begin
                fails++;
                $display("FAIL %s: chg/dsg/sleep actual %b%b%b expected %b%b%b",
                         e.tag, chg_on, dsg_on, slp, e.c, e.d, e.s);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic expect_out(input logic c, input logic d, input logic s,
                              input string tag);
        exp_t e;
        e.c = c; e.d = d; e.s = s; e.tag = tag;
        expq.push_back(e);
        step();
    endtask

    task automatic chk_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        int hi;
        int lo;
        wait_cyc(3);
        rst_n = 1'b1;
        step();
        expect_out(0, 0, 0, "R2 reset state before first scan");
        wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R2 normal after first scan");

        chg_en = 1'b0; step();
        expect_out(0, 1, 0, "R7 charge gated in normal");
        chg_en = 1'b1; step();

        // one failing scan on cell 2 only
        ovt[2] = 1'b1; wait_cyc(DIV * NC); ovt[2] = 1'b0;
        wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R4 single failing scan ignored");

        ovt[2] = 1'b1; ovr[2] = 1'b0; wait_cyc(SETTLE);
        expect_out(0, 1, 0, "R3 overcharge trip");
        dsense = 1'b1; step();
        expect_out(1, 1, 0, "R6 smart discharge on");
        chg_en = 1'b0; step();
        expect_out(0, 1, 0, "R7 smart discharge gated by enable");
        chg_en = 1'b1; dsense = 1'b0; step();
        expect_out(0, 1, 0, "R6 smart discharge off");

        ovt[2] = 1'b0; wait_cyc(SETTLE);
        expect_out(0, 1, 0, "R5 still off inside band");
        ovr[2] = 1'b1; wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R5 released below release level");

        // four-cell default: bit 3 is active
        ovt[3] = 1'b1; ovr[3] = 1'b0; wait_cyc(SETTLE);
        expect_out(0, 1, 0, "R1 cell 3 trips in four-cell mode");
        ovt[3] = 1'b0; ovr[3] = 1'b1; wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R1 cell 3 release in four-cell mode");

        // three-cell mode: bit 3 ignored
        cell3 = 1'b1; wait_cyc(24);
        ovt[3] = 1'b1; ovr[3] = 1'b0; uvt[3] = 1'b1; uvr[3] = 1'b0;
        wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R1 cell 3 ignored in three-cell mode");
        ovt[3] = 1'b0; ovr[3] = 1'b1; uvt[3] = 1'b0; uvr[3] = 1'b1;
        wait_cyc(24);
        cell3 = 1'b0; wait_cyc(24);

        // undervoltage and overcharge together: sleep wins
        ovt[1] = 1'b1; ovr[1] = 1'b0; uvt[1] = 1'b1; uvr[1] = 1'b0;
        wait_cyc(SETTLE);
        expect_out(0, 0, 1, "R8 undervoltage sleep with priority");
        ovt[1] = 1'b0; ovr[1] = 1'b1; uvt[1] = 1'b0; wait_cyc(SETTLE);
        expect_out(0, 0, 1, "R9 sleep held without wake");
        uvr[1] = 1'b1; wait_cyc(SETTLE);
        expect_out(0, 0, 1, "R9 sleep held with all cells released");
        uvr[1] = 1'b0; step();

        wake = 1'b1; wait_cyc(2); wake = 1'b0; step();
        expect_out(chg_on, 0, 1, "R10 recovery keeps discharge off");

        // measure pulse run lengths
        @(negedge clk);
        while (chg_on !== 1'b0) @(negedge clk);
        while (chg_on !== 1'b1) @(negedge clk);
        hi = 0;
        while (chg_on === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (chg_on === 1'b0 && lo < 100) begin lo++; @(negedge clk); end
        chk_val(hi, P_ON,  "R10 pulse on length");
        chk_val(lo, P_OFF, "R10 pulse off length");
        step();

        chg_en = 1'b0; hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (chg_on === 1'b1) hi++;
        end
        chk_val(hi, 0, "R7 no pulses with charge disabled");
        step();
        chg_en = 1'b1;
        wait_cyc(SETTLE);
        chk_val(int'(dsg_on), 0, "R11 recovery persists while a cell is low");

        uvr[1] = 1'b1; wait_cyc(SETTLE);
        expect_out(1, 1, 0, "R11 recovery back to normal");
        wait_cyc(2);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(200000 * 5);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule